// File: doc/BRIEF.md
# Slice Picture Boundary Detector

This block watches a stream of video NAL unit bytes and decides, for every coded slice, whether the slice opens a new picture or continues the picture carried by the slice before it. Upstream logic has already removed emulation-prevention bytes. It delivers one byte per transfer and marks the first byte of each NAL unit with a start flag. For slice units, the block decodes the leading header fields bit by bit. Three of them are unsigned Exp-Golomb codes, and the fourth is a fixed-width frame number. The width of the frame number comes from a configuration pin that software loads from the active parameter set.

Each finished slice produces one result record on a valid/ready output. The record holds the unit type, the first macroblock address, the slice type, the parameter-set id, the frame number and a new-picture flag. Downstream logic uses the flag to gather several slice units into one access unit. Non-slice units, and the slice bytes that follow the frame number, are consumed without any effect.

Back-pressure works as follows. An input byte transfers only on a cycle where `in_valid` and `in_ready` are both high. The block drops `in_ready` while it serialises a slice byte, which takes eight cycles. It also drops `in_ready` while a result record waits to be taken. The block holds a record on the output until `out_ready` is high at a clock edge, and the record does not change while it waits.

Top module: `slice_boundary_detector`

## Requirements
- R1: The unit type is bits [4:0] of the byte carrying `in_sof`. Only type 1 and type 5 units yield a record. Any other type yields none and leaves the picture grouping untouched.
- R2: Slice header bits start with the most significant bit of the byte after the type byte. The block decodes first macroblock, slice type and parameter-set id in that order as unsigned Exp-Golomb codes. A code is N zero bits, a one, then N bits holding v, and it decodes to 2^N - 1 + v. Values up to 0xFFFFFFFE are exact.
- R3: The frame number is the next `cfg_fn_extra` + 4 bits, most significant first. The configuration is sampled when the type byte is accepted and covers 0 to 12.
- R4: A slice whose frame number equals that of the last recorded slice gets `out_new_pic` = 0. A different frame number gets 1.
- R5: The first slice record after reset always has `out_new_pic` = 1.
- R6: A type 5 slice that follows a type 1 slice has `out_new_pic` = 1, even when the frame numbers match.
- R7: A code with 32 leading zeros yields a record with `out_err` = 1 and `out_new_pic` = 0. That record does not change the stored frame number, and the rest of the unit is ignored.
- R8: Bytes that follow the frame number, up to the next `in_sof`, are accepted and have no effect.
- R9: If a unit ends with a start flag before its frame number is complete, it yields no record and leaves the stored frame number unchanged.
- R10: While `out_valid` is high and `out_ready` is low, the record holds steady and `in_ready` stays low.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | NAL payload byte |
| in_sof | input | 1 | Byte is the first of a NAL unit |
| cfg_fn_extra | input | CFG_W | Frame-number width minus 4 |
| out_valid | output | 1 | Result record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_nal_type | output | 5 | Unit type of the slice |
| out_first_mb | output | VAL_W | First macroblock address |
| out_slice_type | output | VAL_W | Slice type code |
| out_pps_id | output | VAL_W | Parameter-set id |
| out_frame_num | output | FN_W | Frame number |
| out_new_pic | output | 1 | Slice opens a new picture |
| out_err | output | 1 | Exp-Golomb code out of range |

## Verification
The main vector loop encodes slices with an independent Exp-Golomb encoder. Some slices share a frame number with the slice before them and some do not. The loop varies the frame-number width across 4, 8 and 16 bits and runs the code lengths from one bit up to the longest legal code. This separates equality grouping from the rules for the first slice and for an IDR slice after a non-IDR slice.

Directed cases cover a parameter-set unit placed between two slices of the same picture, an over-long code and a truncated slice. Each of these is followed by a slice whose flag is wrong if the tracker was disturbed. A stalled consumer shows that the record holds and the input stalls. A second reset shows that the first-slice rule returns.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  typedef enum logic [1:0] {M_IDLE, M_PARSE, M_SKIP} parse_mode_t;
  typedef enum logic [1:0] {F_MB, F_STYPE, F_PPS, F_FNUM} hdr_field_t;
  typedef enum logic {PH_ZEROS, PH_SUFFIX} ue_phase_t;
  localparam logic [4:0] NAL_SLICE     = 5'd1;
  localparam logic [4:0] NAL_IDR_SLICE = 5'd5;
endpackage

// File: rtl/sbd_bit_feeder.sv
module sbd_bit_feeder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data,
  input  logic       shift,
  input  logic       flush,
  output logic       bit_out,
  output logic       has_bits
);
  logic [7:0] sh;
  logic [3:0] left;

  assign bit_out  = sh[7];
  assign has_bits = (left != 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (flush) begin
      left <= '0;
    end else if (load) begin
      sh   <= data;
      left <= 4'd8;
    end else if (shift && has_bits) begin
      sh   <= {sh[6:0], 1'b0};
      left <= left - 4'd1;
    end
  end
endmodule

// File: rtl/sbd_ue_decoder.sv
module sbd_ue_decoder #(
  parameter int VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic             done,
  output logic             err,
  output logic [VAL_W-1:0] value
);
  import sbd_pkg::*;
  localparam int LZ_W = $clog2(VAL_W);
  localparam logic [LZ_W-1:0] LZ_MAX = LZ_W'(VAL_W - 1);
  localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

  ue_phase_t        phase;
  logic [LZ_W-1:0]  lz;
  logic [LZ_W-1:0]  remain;
  logic [VAL_W-1:0] acc;
  logic [VAL_W-1:0] acc_nx;

  assign acc_nx = {acc[VAL_W-2:0], bit_in};

  always_comb begin
    done  = 1'b0;
    err   = 1'b0;
    value = '0;
    if (bit_en) begin
      if (phase == PH_ZEROS) begin
        if (bit_in && lz == '0) done = 1'b1;
        else if (!bit_in && lz == LZ_MAX) err = 1'b1;
      end else if (remain == LZ_W'(1)) begin
        done  = 1'b1;
        value = ((ONE << lz) | acc_nx) - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_ZEROS;
      lz     <= '0;
      remain <= '0;
      acc    <= '0;
    end else if (clr) begin
      phase  <= PH_ZEROS;
      lz     <= '0;
      remain <= '0;
      acc    <= '0;
    end else if (bit_en) begin
      if (phase == PH_ZEROS) begin
        if (bit_in) begin
          if (lz != '0) begin
            phase  <= PH_SUFFIX;
            remain <= lz;
            acc    <= '0;
          end
        end else if (lz == LZ_MAX) begin
          lz <= '0;
        end else begin
          lz <= lz + LZ_W'(1);
        end
      end else begin
        acc    <= acc_nx;
        remain <= remain - LZ_W'(1);
        if (remain == LZ_W'(1)) begin
          phase <= PH_ZEROS;
          lz    <= '0;
          acc   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sbd_fixed_reader.sv
module sbd_fixed_reader #(
  parameter int FN_W = 16,
  localparam int CW = $clog2(FN_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            bit_en,
  input  logic            bit_in,
  input  logic [CW-1:0]   nbits,
  output logic            done,
  output logic [FN_W-1:0] value
);
  logic [CW-1:0]   taken;
  logic [FN_W-1:0] acc;

  assign value = {acc[FN_W-2:0], bit_in};
  assign done  = bit_en && ((taken + CW'(1)) == nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken <= '0;
      acc   <= '0;
    end else if (clr || done) begin
      taken <= '0;
      acc   <= '0;
    end else if (bit_en) begin
      taken <= taken + CW'(1);
      acc   <= value;
    end
  end
endmodule

// File: rtl/sbd_pic_tracker.sv
module sbd_pic_tracker #(
  parameter int FN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [FN_W-1:0] cur_fn,
  input  logic            cur_idr,
  output logic            new_pic
);
  logic            have_prev;
  logic [FN_W-1:0] prev_fn;
  logic            prev_idr;

  assign new_pic = !have_prev || (cur_fn != prev_fn) || (cur_idr && !prev_idr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_fn   <= '0;
      prev_idr  <= 1'b0;
    end else if (upd) begin
      have_prev <= 1'b1;
      prev_fn   <= cur_fn;
      prev_idr  <= cur_idr;
    end
  end
endmodule

// File: rtl/slice_boundary_detector.sv
module slice_boundary_detector #(
  parameter int VAL_W = 32,
  parameter int FN_W  = 16,
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic [CFG_W-1:0] cfg_fn_extra,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [4:0]       out_nal_type,
  output logic [VAL_W-1:0] out_first_mb,
  output logic [VAL_W-1:0] out_slice_type,
  output logic [VAL_W-1:0] out_pps_id,
  output logic [FN_W-1:0]  out_frame_num,
  output logic             out_new_pic,
  output logic             out_err
);
  import sbd_pkg::*;
  localparam int CW = $clog2(FN_W + 1);

  parse_mode_t      mode;
  hdr_field_t       field;
  logic [4:0]       type_q;
  logic [CW-1:0]    fbits_q;
  logic [VAL_W-1:0] mb_q, st_q, pps_q;
  logic             pend;

  logic accept, sof_acc, load, bit_en, ue_en, fx_en, flush;
  logic fb_bit, fb_has;
  logic ue_done, ue_err;
  logic [VAL_W-1:0] ue_val;
  logic fx_done;
  logic [FN_W-1:0] fx_val;
  logic tr_new;
  logic is_slice;
  logic [CW:0]   fsum;
  logic [CW-1:0] fbits_nx;

  assign in_ready  = !pend && ((mode != M_PARSE) || !fb_has);
  assign accept    = in_valid && in_ready;
  assign sof_acc   = accept && in_sof;
  assign load      = accept && !in_sof && (mode == M_PARSE);
  assign bit_en    = (mode == M_PARSE) && fb_has;
  assign ue_en     = bit_en && (field != F_FNUM);
  assign fx_en     = bit_en && (field == F_FNUM);
  assign flush     = sof_acc || ue_err || fx_done;
  assign is_slice  = (in_data[4:0] == NAL_SLICE) || (in_data[4:0] == NAL_IDR_SLICE);
  assign out_valid = pend;

  assign fsum     = {{(CW + 1 - CFG_W){1'b0}}, cfg_fn_extra} + (CW + 1)'(4);
  assign fbits_nx = (fsum > (CW + 1)'(FN_W)) ? CW'(FN_W) : fsum[CW-1:0];

  sbd_bit_feeder u_feed (
    .clk(clk), .rst_n(rst_n), .load(load), .data(in_data),
    .shift(bit_en), .flush(flush), .bit_out(fb_bit), .has_bits(fb_has)
  );

  sbd_ue_decoder #(.VAL_W(VAL_W)) u_ue (
    .clk(clk), .rst_n(rst_n), .clr(sof_acc), .bit_en(ue_en), .bit_in(fb_bit),
    .done(ue_done), .err(ue_err), .value(ue_val)
  );

  sbd_fixed_reader #(.FN_W(FN_W)) u_fx (
    .clk(clk), .rst_n(rst_n), .clr(sof_acc), .bit_en(fx_en), .bit_in(fb_bit),
    .nbits(fbits_q), .done(fx_done), .value(fx_val)
  );

  sbd_pic_tracker #(.FN_W(FN_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .upd(fx_done), .cur_fn(fx_val),
    .cur_idr(type_q == NAL_IDR_SLICE), .new_pic(tr_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode           <= M_IDLE;
      field          <= F_MB;
      type_q         <= '0;
      fbits_q        <= '0;
      mb_q           <= '0;
      st_q           <= '0;
      pps_q          <= '0;
      pend           <= 1'b0;
      out_nal_type   <= '0;
      out_first_mb   <= '0;
      out_slice_type <= '0;
      out_pps_id     <= '0;
      out_frame_num  <= '0;
      out_new_pic    <= 1'b0;
      out_err        <= 1'b0;
    end else begin
      if (pend && out_ready) pend <= 1'b0;
      if (sof_acc) begin
        type_q  <= in_data[4:0];
        mode    <= is_slice ? M_PARSE : M_SKIP;
        field   <= F_MB;
        fbits_q <= fbits_nx;
      end else if (ue_err) begin
        mode           <= M_SKIP;
        pend           <= 1'b1;
        out_nal_type   <= type_q;
        out_first_mb   <= mb_q;
        out_slice_type <= st_q;
        out_pps_id     <= pps_q;
        out_frame_num  <= '0;
        out_new_pic    <= 1'b0;
        out_err        <= 1'b1;
      end else if (ue_done) begin
        case (field)
          F_MB:    begin mb_q  <= ue_val; field <= F_STYPE; end
          F_STYPE: begin st_q  <= ue_val; field <= F_PPS;   end
          default: begin pps_q <= ue_val; field <= F_FNUM;  end
        endcase
      end else if (fx_done) begin
        mode           <= M_SKIP;
        pend           <= 1'b1;
        out_nal_type   <= type_q;
        out_first_mb   <= mb_q;
        out_slice_type <= st_q;
        out_pps_id     <= pps_q;
        out_frame_num  <= fx_val;
        out_new_pic    <= tr_new;
        out_err        <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker #(
  parameter int FN_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [4:0]      out_nal_type,
  input logic [FN_W-1:0] out_frame_num,
  input logic            out_new_pic,
  input logic            out_err
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else if (out_valid && out_ready && !out_err) seen <= 1'b1;
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_frame_num)
      && $stable(out_new_pic) && $stable(out_nal_type) && $stable(out_err));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r7_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> !out_new_pic);

  a_r1_slice_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nal_type == 5'd1) || (out_nal_type == 5'd5));

  a_r5_first_new: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err && !seen |-> out_new_pic);
endmodule

bind slice_boundary_detector sbd_checker #(.FN_W(FN_W)) u_sbd_checker (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_nal_type(out_nal_type),
  .out_frame_num(out_frame_num), .out_new_pic(out_new_pic), .out_err(out_err)
);

// File: tb/test_slice_boundary_detector.sv
module test_slice_boundary_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic [3:0]  cfg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  o_ty;
  logic [31:0] o_mb, o_st, o_pps;
  logic [15:0] o_fn;
  logic        o_new, o_err;

  always #10 clk = ~clk;

  slice_boundary_detector i_slice_boundary_detector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .cfg_fn_extra(cfg),
    .out_valid(out_valid), .out_ready(out_ready), .out_nal_type(o_ty),
    .out_first_mb(o_mb), .out_slice_type(o_st), .out_pps_id(o_pps),
    .out_frame_num(o_fn), .out_new_pic(o_new), .out_err(o_err)
  );

  int checks = 0;
  int fails = 0;
  int got = 0;
  logic [4:0]  g_ty;
  logic [31:0] g_mb, g_st, g_pps;
  logic [15:0] g_fn;
  logic        g_new, g_err;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      got++;
      g_ty = o_ty; g_mb = o_mb; g_st = o_st; g_pps = o_pps;
      g_fn = o_fn; g_new = o_new; g_err = o_err;
    end
  end

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [0:255] bb;
  int nb;

  task automatic put_bit(logic b);
    bb[nb] = b;
    nb++;
  endtask

  task automatic put_ue(longint unsigned v);
    longint unsigned x = v + 1;
    int n = 0;
    while ((x >> (n + 1)) != 0) n++;
    for (int i = 0; i < n; i++) put_bit(1'b0);
    for (int i = n; i >= 0; i--) put_bit(x[i]);
  endtask

  task automatic send_byte(logic [7:0] d, logic s);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic send_slice(logic [4:0] ty, logic [3:0] c, logic [31:0] mb,
                            logic [31:0] st, logic [31:0] pps, logic [15:0] fn,
                            bit extra);
    nb = 0;
    put_ue(mb); put_ue(st); put_ue(pps);
    for (int i = int'(c) + 3; i >= 0; i--) put_bit(fn[i]);
    while (nb % 8 != 0) put_bit(1'b1);
    cfg = c;
    send_byte({3'b011, ty}, 1'b1);
    for (int k = 0; k < nb / 8; k++) send_byte(bb[k*8 +: 8], 1'b0);
    if (extra) begin
      send_byte(8'h00, 1'b0);
      send_byte(8'h00, 1'b0);
      send_byte(8'hC3, 1'b0);
    end
    repeat (12) @(negedge clk);
  endtask

  typedef struct packed {
    logic [4:0]  ty;
    logic [3:0]  cfg;
    logic [31:0] mb;
    logic [31:0] st;
    logic [31:0] pps;
    logic [15:0] fn;
    logic        nw;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{5'd5, 4'd0,  32'd0,          32'd7, 32'd0,   16'h0,    1'b1},
    '{5'd5, 4'd0,  32'd99,         32'd7, 32'd0,   16'h0,    1'b0},
    '{5'd1, 4'd0,  32'd0,          32'd5, 32'd1,   16'h1,    1'b1},
    '{5'd1, 4'd0,  32'd300,        32'd5, 32'd1,   16'h1,    1'b0},
    '{5'd1, 4'd4,  32'd0,          32'd0, 32'd2,   16'd200,  1'b1},
    '{5'd1, 4'd4,  32'd65535,      32'd0, 32'd2,   16'd200,  1'b0},
    '{5'd5, 4'd4,  32'd0,          32'd2, 32'd0,   16'd200,  1'b1},
    '{5'd1, 4'd0,  32'd0,          32'd6, 32'd255, 16'hF,    1'b1},
    '{5'd1, 4'd0,  32'hFFFFFFFE,   32'd1, 32'd3,   16'hF,    1'b0},
    '{5'd1, 4'd12, 32'd5,          32'd0, 32'd0,   16'hABCD, 1'b1},
    '{5'd1, 4'd12, 32'd6,          32'd0, 32'd0,   16'hABCD, 1'b0}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R11 out_valid in reset", out_valid, 0);
    chk("R11 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 out_valid after reset", out_valid, 0);
    chk("R11 in_ready after reset", in_ready, 1);

    // R2 R3 R4 R5 R6 R8: vector table, each slice followed by ignored bytes
    for (int v = 0; v < NV; v++) begin
      base = got;
      send_slice(VEC[v].ty, VEC[v].cfg, VEC[v].mb, VEC[v].st, VEC[v].pps,
                 VEC[v].fn, 1'b1);
      chk("R8 one record per slice", got, base + 1);
      chk("R1 type", g_ty, VEC[v].ty);
      chk("R2 first_mb", g_mb, VEC[v].mb);
      chk("R2 slice_type", g_st, VEC[v].st);
      chk("R2 pps_id", g_pps, VEC[v].pps);
      chk("R3 frame_num", g_fn, VEC[v].fn);
      chk("R4 R5 R6 new_pic", g_new, VEC[v].nw);
      chk("R7 no error", g_err, 0);
    end

    // R1: parameter-set unit yields nothing and leaves grouping alone
    base = got;
    send_byte(8'h67, 1'b1);
    send_byte(8'h42, 1'b0);
    send_byte(8'h00, 1'b0);
    send_byte(8'h1E, 1'b0);
    repeat (12) @(negedge clk);
    chk("R1 no record for type 7", got, base);
    send_slice(5'd1, 4'd12, 32'd7, 32'd0, 32'd0, 16'hABCD, 1'b0);
    chk("R1 grouping kept across type 7", g_new, 0);

    // R7: 32 leading zeros
    base = got;
    send_byte(8'h41, 1'b1);
    for (int k = 0; k < 4; k++) send_byte(8'h00, 1'b0);
    repeat (12) @(negedge clk);
    chk("R7 record on error", got, base + 1);
    chk("R7 err flag", g_err, 1);
    chk("R7 new_pic low", g_new, 0);
    send_byte(8'hFF, 1'b0);
    send_byte(8'h80, 1'b0);
    repeat (12) @(negedge clk);
    chk("R7 rest of unit ignored", got, base + 1);
    send_slice(5'd1, 4'd12, 32'd8, 32'd0, 32'd0, 16'hABCD, 1'b0);
    chk("R7 tracker unchanged", g_new, 0);

    // R9: truncated slice
    base = got;
    send_byte(8'h41, 1'b1);
    send_byte(8'h80, 1'b0);
    repeat (12) @(negedge clk);
    send_slice(5'd1, 4'd12, 32'd9, 32'd0, 32'd0, 16'hABCD, 1'b0);
    chk("R9 only full slice recorded", got, base + 1);
    chk("R9 tracker unchanged", g_new, 0);
    chk("R9 fields of next slice", g_mb, 9);

    // R10: back-pressure
    @(posedge clk); #1 out_ready = 1'b0;
    base = got;
    send_slice(5'd1, 4'd12, 32'd10, 32'd0, 32'd0, 16'h1234, 1'b0);
    chk("R10 valid held", out_valid, 1);
    chk("R10 input stalled", in_ready, 0);
    repeat (4) @(negedge clk);
    chk("R10 still valid", out_valid, 1);
    chk("R10 frame stable", o_fn, 16'h1234);
    chk("R10 new_pic stable", o_new, 1);
    chk("R10 not consumed", got, base);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 consumed once", got, base + 1);
    chk("R10 valid drops", out_valid, 0);
    chk("R10 input resumes", in_ready, 1);

    // R5: rule returns after a fresh reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 out_valid in second reset", out_valid, 0);
    rst_n = 1'b1;
    send_slice(5'd1, 4'd12, 32'd0, 32'd0, 32'd0, 16'h1234, 1'b0);
    chk("R5 first slice after reset", g_new, 1);

    summary();
  end
endmodule